// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block turns a short command word into the carrier-gating pattern a reader uses to talk to a tag. The reader keeps its field switched on. It signals each bit by cutting the carrier for a fixed gap and then restoring it for a time that depends on the bit value. A long carrier-on time means a one and a short one means a zero. Bits leave least-significant first, and one more gap after the last bit closes the frame. After that the block keeps its carrier on for a fixed listen window, so the tag's reply has time to arrive before another frame can begin.

All timing is counted on a tick enable that runs at 1.5 MHz (a 48 MHz clock divided by 32). The default gap is 30 ticks (20 µs). A one bit lasts 120 ticks in total and a zero bit lasts 60 ticks. The listen window is 495 ticks (330 µs). Any payload scrambling happens upstream, so the word that arrives is sent exactly as given.

The request side is a valid/ready port. Ready is high only while the block is idle. A request is taken on a clock where valid and ready are both high. While ready is low the requester has to hold or retry; nothing it presents is queued. Status pins are plain signals.

Top module: `pp_frame_tx`

## Requirements
- R1: After reset the block is idle. `coil_on` is 1, `frm_ready` is 1, and `busy`, `done` and `len_err` are 0.
- R2: Every bit opens with a carrier-off gap (`coil_on` = 0) of PAUSE_T ticks. The first gap begins in the clock after the request is taken.
- R3: After its gap, a bit whose value is 1 keeps the carrier on for ONE_T−PAUSE_T ticks. A bit whose value is 0 keeps it on for ZERO_T−PAUSE_T ticks. A whole bit therefore lasts ONE_T or ZERO_T ticks.
- R4: Bits are sent starting at `frm_data[0]` and moving upward through the word.
- R5: After the last bit, a closing gap of PAUSE_T ticks with the carrier off ends the frame.
- R6: `done` is high for exactly one clock. That clock is the one right after the closing gap ends, and it happens once per frame.
- R7: After the closing gap, `busy` stays 1 and `coil_on` stays 1 for LISTEN_T ticks. Once that window has elapsed, `busy` falls and `frm_ready` rises.
- R8: `frm_ready` equals the inverse of `busy`. A request presented while `frm_ready` is 0 does not change the frame in flight and does not start a new one.
- R9: A request taken with `frm_len` equal to 0 or greater than MAX_BITS raises `len_err` for one clock. In that case nothing is transmitted: `coil_on` stays 1 and `busy` stays 0.
- R10: Timers advance only on clocks where `tick` is 1. Between ticks, `coil_on` and `done` do not change.
- R11: Every length from 1 to MAX_BITS is accepted. Bits of `frm_data` at or above `frm_len` have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing enable, one clock per tick |
| frm_valid | input | 1 | Request to send a frame |
| frm_ready | output | 1 | Block is idle and will take a request |
| frm_data | input | MAX_BITS | Frame payload, sent starting from bit 0 |
| frm_len | input | LEN_W | Number of bits to send |
| coil_on | output | 1 | Carrier gate (1 = carrier on) |
| busy | output | 1 | Frame or listen window in progress |
| done | output | 1 | One-clock pulse when the closing gap ends |
| len_err | output | 1 | One-clock pulse when a request has a bad length |

## Verification
The case that needs care is the last clock of the listen window. In that clock the window expires and ready rises, and a pending request can be taken straight away. To provoke it, the bench raises valid with a second frame partway through the listen window and holds it there. It judges the result in two ways. The first frame's waveform and its `done` timing must be unchanged. The second frame's opening gap must appear after exactly one idle clock, with its full expected shape, for tick spacings of both one and two clocks.

// File: rtl/pp_tx_pkg.sv
package pp_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_MARK,
    ST_TAIL,
    ST_LISTEN
  } tx_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pp_tick_timer.sv
module pp_tick_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = tick && (cnt == '0);

  // R10
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/pp_bit_shift.sv
module pp_bit_shift #(
  parameter int DW = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic [LW-1:0] len,
  input  logic          adv,
  output logic          cur_bit,
  output logic          last
);

  logic [DW-1:0] sr;
  logic [LW-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      rem <= '0;
    end else if (load) begin
      sr  <= din;
      rem <= len;
    end else if (adv) begin
      sr  <= sr >> 1;
      rem <= rem - 1'b1;
    end
  end

  assign cur_bit = sr[0];
  assign last    = (rem == LW'(1));

  // R4
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (rem > LW'(1)));

endmodule

// File: rtl/pp_frame_tx.sv
module pp_frame_tx
  import pp_tx_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int PAUSE_T  = 30,
  parameter int ONE_T    = 120,
  parameter int ZERO_T   = 60,
  parameter int LISTEN_T = 495,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                frm_valid,
  output logic                frm_ready,
  input  logic [MAX_BITS-1:0] frm_data,
  input  logic [LEN_W-1:0]    frm_len,
  output logic                coil_on,
  output logic                busy,
  output logic                done,
  output logic                len_err
);

  localparam int ONE_ON  = ONE_T - PAUSE_T;
  localparam int ZERO_ON = ZERO_T - PAUSE_T;
  localparam int MAXT    = int'(max3(PAUSE_T, max3(ONE_ON, ZERO_ON, 1), LISTEN_T));
  localparam int TW      = $clog2(MAXT + 1);

  tx_state_e      state, nxt;
  logic           coil_q, nxt_coil;
  logic           done_q, err_q;
  logic           tm_load, expire;
  logic [TW-1:0]  tm_val;
  logic           sh_load, sh_adv, cur_bit, last;
  logic           fin, bad, accept, len_ok;

  pp_tick_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(tm_load), .load_val(tm_val), .expire(expire)
  );

  pp_bit_shift #(.DW(MAX_BITS), .LW(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(frm_data), .len(frm_len),
    .adv(sh_adv), .cur_bit(cur_bit), .last(last)
  );

  assign busy      = (state != ST_IDLE);
  assign frm_ready = !busy;
  assign accept    = frm_valid && frm_ready;
  assign len_ok    = (frm_len != '0) && (int'(frm_len) <= MAX_BITS);

  always_comb begin
    nxt      = state;
    nxt_coil = coil_q;
    tm_load  = 1'b0;
    tm_val   = '0;
    sh_load  = 1'b0;
    sh_adv   = 1'b0;
    fin      = 1'b0;
    bad      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (len_ok) begin
            sh_load  = 1'b1;
            tm_load  = 1'b1;
            tm_val   = TW'(PAUSE_T - 1);
            nxt      = ST_GAP;
            nxt_coil = 1'b0;
          end else begin
            bad = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (expire) begin
          tm_load  = 1'b1;
          tm_val   = cur_bit ? TW'(ONE_ON - 1) : TW'(ZERO_ON - 1);
          nxt      = ST_MARK;
          nxt_coil = 1'b1;
        end
      end
      ST_MARK: begin
        if (expire) begin
          tm_load  = 1'b1;
          tm_val   = TW'(PAUSE_T - 1);
          nxt_coil = 1'b0;
          if (last) begin
            nxt = ST_TAIL;
          end else begin
            nxt    = ST_GAP;
            sh_adv = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (expire) begin
          tm_load  = 1'b1;
          tm_val   = TW'(LISTEN_T - 1);
          nxt      = ST_LISTEN;
          nxt_coil = 1'b1;
          fin      = 1'b1;
        end
      end
      ST_LISTEN: begin
        if (expire) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      coil_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      state  <= nxt;
      coil_q <= nxt_coil;
      done_q <= fin;
      err_q  <= bad;
    end
  end

  assign coil_on = coil_q;
  assign done    = done_q;
  assign len_err = err_q;

  // R2
  gap_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coil_on |-> busy);

  // R2
  frame_opens_with_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !coil_on);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_in_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && coil_on));

  // R8
  start_needs_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frm_valid && frm_ready));

  // R9
  err_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (!busy && coil_on));

endmodule

// File: tb/sim_pp_frame_tx.sv
module sim_pp_frame_tx;

  localparam int MAXB = 32;
  localparam int P    = 2;
  localparam int ONE  = 6;
  localparam int ZERO = 4;
  localparam int LIS  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [31:0] frm_data = '0;
  logic [5:0]  frm_len = '0;
  logic        coil_on, busy, done, len_err;

  int total = 0;
  int bad = 0;
  int div = 1;
  int tcnt = 0;

  logic exp_w [0:4095];
  logic rec_w [0:4095];
  int   exp_n, rec_n, done_idx, done_cnt, stray, rdy_bad;
  logic end_ready;

  pp_frame_tx #(
    .MAX_BITS(MAXB), .PAUSE_T(P), .ONE_T(ONE), .ZERO_T(ZERO), .LISTEN_T(LIS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_data(frm_data), .frm_len(frm_len),
    .coil_on(coil_on), .busy(busy), .done(done), .len_err(len_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (div <= 1) tick = 1'b1;
    else begin
      tcnt = (tcnt + 1) % div;
      tick = (tcnt == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic build_exp(input logic [31:0] d, input int len);
    exp_n = 0;
    for (int b = 0; b < len; b++) begin
      for (int k = 0; k < P; k++) begin exp_w[exp_n] = 1'b0; exp_n++; end
      for (int k = 0; k < (d[b] ? ONE - P : ZERO - P); k++) begin
        exp_w[exp_n] = 1'b1; exp_n++;
      end
    end
    for (int k = 0; k < P; k++) begin exp_w[exp_n] = 1'b0; exp_n++; end
    for (int k = 0; k < LIS; k++) begin exp_w[exp_n] = 1'b1; exp_n++; end
  endtask

  task automatic capture(input bit intrude, input bit chain,
                         input logic [31:0] cdata, input logic [5:0] clen);
    bit first = 1'b1;
    bit next_tick = 1'b0;
    bit chained = 1'b0;
    rec_n = 0; done_idx = -1; done_cnt = 0; stray = 0; rdy_bad = 0;
    @(posedge clk);
    for (int it = 0; it < 20000; it++) begin
      @(negedge clk);
      if (first) frm_valid = 1'b0;
      if (!busy) break;
      if (done) done_cnt++;
      if (frm_ready) rdy_bad++;
      if (first || next_tick) begin
        rec_w[rec_n] = coil_on;
        if (done) done_idx = rec_n;
        rec_n++;
      end else begin
        if (coil_on != rec_w[rec_n-1]) stray++;
        if (done) stray++;
      end
      if (intrude && it == 4) begin
        frm_valid = 1'b1; frm_data = 32'hFFFF_FFFF; frm_len = 6'd3;
      end
      if (intrude && it == 9) frm_valid = 1'b0;
      if (chain && !chained && rec_n == exp_n - 1) begin
        chained = 1'b1;
        frm_valid = 1'b1; frm_data = cdata; frm_len = clen;
      end
      next_tick = tick;
      first = 1'b0;
    end
    end_ready = frm_ready;
  endtask

  task automatic judge(input string tag);
    int mism = 0;
    for (int i = 0; i < exp_n && i < rec_n; i++)
      if (rec_w[i] !== exp_w[i]) mism++;
    chk(rec_n == exp_n, "R2 R5 R7", {tag, " frame length in ticks"}, rec_n, exp_n);
    chk(mism == 0, "R2 R3 R4 R5 R11", {tag, " tick waveform mismatches"}, mism, 0);
    chk(done_idx == exp_n - LIS, "R6", {tag, " done position"}, done_idx, exp_n - LIS);
    chk(done_cnt == 1, "R6", {tag, " done pulses"}, done_cnt, 1);
    chk(stray == 0, "R10", {tag, " changes between ticks"}, stray, 0);
    chk(rdy_bad == 0, "R8", {tag, " ready while busy"}, rdy_bad, 0);
    chk(end_ready == 1'b1, "R7", {tag, " ready after window"}, end_ready, 1);
  endtask

  task automatic send(input logic [31:0] d, input int len, input bit intrude,
                      input string tag);
    build_exp(d, len);
    @(negedge clk);
    frm_valid = 1'b1; frm_data = d; frm_len = 6'(len);
    capture(intrude, 1'b0, '0, '0);
    judge(tag);
  endtask

  task automatic bad_len(input int len);
    @(negedge clk);
    frm_valid = 1'b1; frm_data = 32'h1234_5678; frm_len = 6'(len);
    @(negedge clk);
    frm_valid = 1'b0;
    chk(len_err == 1'b1, "R9", $sformatf("len %0d err pulse", len), len_err, 1);
    chk(busy == 1'b0 && coil_on == 1'b1, "R9", $sformatf("len %0d no frame", len),
        {busy, coil_on}, 1);
    @(negedge clk);
    chk(len_err == 1'b0, "R9", $sformatf("len %0d err one clock", len), len_err, 0);
    chk(coil_on == 1'b1 && frm_ready == 1'b1, "R9", "still idle", {coil_on, frm_ready}, 3);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(coil_on == 1'b1, "R1", "coil during reset", coil_on, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(coil_on == 1'b1 && frm_ready == 1'b1, "R1", "idle after reset",
        {coil_on, frm_ready}, 3);
    chk(busy == 1'b0 && done == 1'b0 && len_err == 1'b0, "R1", "flags after reset",
        {busy, done, len_err}, 0);

    // R11 sweep every length with high garbage bits, tick every clock
    for (int l = 1; l <= MAXB; l++)
      send(32'hA5C3_9E17 ^ (32'(l) * 32'h0101_0101), l, 1'b0, $sformatf("len%0d", l));
    send(32'hFFFF_FFFF, 32, 1'b0, "all ones");
    send(32'h0000_0000, 32, 1'b0, "all zeros");
    send(32'hFFFF_FFFE, 1, 1'b0, "single zero");

    // R8 requests during busy are ignored
    send(32'h0000_00B4, 8, 1'b1, "intrude");

    // R9 bad lengths
    bad_len(0);
    bad_len(33);
    bad_len(63);

    // R10 sparse ticks
    div = 3;
    send(32'h0000_5A3C, 16, 1'b0, "div3");
    send(32'h8000_0001, 32, 1'b1, "div3 intrude");

    // R7 R8 request waiting at end of listen window, two tick spacings
    for (int dv = 1; dv <= 2; dv++) begin
      div = dv;
      build_exp(32'h0000_0036, 6);
      @(negedge clk);
      frm_valid = 1'b1; frm_data = 32'h0000_0036; frm_len = 6'd6;
      capture(1'b0, 1'b1, 32'h0000_0159, 6'd9);
      judge($sformatf("chain first div%0d", dv));
      chk(frm_valid == 1'b1, "R8", "request held at window end", frm_valid, 1);
      build_exp(32'h0000_0159, 9);
      capture(1'b0, 1'b0, '0, '0);
      judge($sformatf("chain second div%0d", dv));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule